// File: doc/BRIEF.md
# Two-Byte-Addressed Paged Memory Slave on a Two-Wire Bus

This block is a target-only agent on an open-drain two-wire serial bus (a clock line and a data line). It holds a small byte memory in registers and answers to one fixed 7-bit device address. After the device byte, a write message first carries a two-byte internal address, high byte first. Any further bytes in the same message are collected in a one-page buffer. They reach the memory only when the message closes with STOP.

Reads start from the internal pointer, which a write of the two address bytes loads. The usual random read is that address write, then a repeated START, then the device byte with the read bit set. The pointer advances after every byte sent and wraps at the top of memory. A STOP that commits data opens a busy window. While the window is open, the block refuses its own address. Bus lines are sampled by the system clock through synchronizers. The block only ever pulls the data line low, through `sda_oe`.

Top module: `i2c_paged_mem_slave`

## Requirements
- R1: The first byte after any START holds a 7-bit device address, most significant bit first, then a direction bit (0 = write, 1 = read). The block pulls the data line low in the ninth clock (ACK) only when the address equals `DEV_ADDR` and no busy window is open. Otherwise it leaves the line released (NACK).
- R2: In a write message the first data byte is the high internal address byte and the second is the low byte. Address bits above `MEM_AW` are ignored. Every data byte is acknowledged, and later bytes are stored starting at that address.
- R3: Stored bytes stay inside one page of 2^`PAGE_AW` bytes (32 by default). The low `PAGE_AW` pointer bits advance and wrap within the page, and the upper bits stay fixed.
- R4: An address-only write, a repeated START and a read-direction device byte return data starting at the latched address.
- R5: After each byte sent, the pointer increments across the whole memory and wraps from the top address to address 0.
- R6: When the controller answers a sent byte with NACK, the block releases the data line and drives nothing until the next START or STOP.
- R7: A STOP that ends a write holding at least one data byte starts a busy window of `BUSY_CYCLES` clocks. Within it the block NACKs its own address. A write of address bytes only opens no busy window.
- R8: The block changes `sda_oe` only while the sampled clock line is low. Received bits are taken at the rising clock edge.
- R9: A START seen at any point, including in the middle of a byte, returns the block to device-address reception with a cleared bit count. Data bytes buffered but not yet committed by STOP are discarded.
- R10: After reset the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Some rules are checked by assertions on every cycle:
- the data drive moves only while the sampled clock is low;
- an ACK to a device byte never happens without an address match;
- no ACK is given during a busy window;
- the page bits of the pointer stay fixed while a burst is buffered;
- every START lands in address reception with a zero bit count;
- the line is released once a read is abandoned.

Other behaviour needs whole bus transactions and only the bench scenarios can show it:
- commit at STOP;
- discard on repeated or mid-byte START;
- in-page wrap;
- wrap at the top of memory;
- the ignored high address bits;
- the length of the busy window and the case where it does not open.

// File: rtl/i2cpm_pkg.sv
package i2cpm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_WRX,
        S_WACK,
        S_TX,
        S_RACK,
        S_WAIT
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [7:0] devbyte, input logic [6:0] dev);
        return devbyte[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2cpm_line_sync.sv
module i2cpm_line_sync
    import i2cpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t ev,
    output logic     scl_q
);
    logic [2:0] scl_s;
    logic [2:0] sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s <= 3'b111;
            sda_s <= 3'b111;
        end else begin
            scl_s <= {scl_s[1:0], scl_i};
            sda_s <= {sda_s[1:0], sda_i};
        end
    end

    // index 1 is the settled sample, index 2 is the previous one
    always_comb begin
        ev.rise  = scl_s[1] & ~scl_s[2];
        ev.fall  = ~scl_s[1] & scl_s[2];
        ev.start = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
        ev.stop  = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
        ev.sda   = sda_s[1];
    end

    assign scl_q = scl_s[1];

endmodule

// File: rtl/i2cpm_store.sv
module i2cpm_store #(
    parameter int MEM_AW  = 8,
    parameter int PAGE_AW = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      buf_we,
    input  logic [PAGE_AW-1:0]        buf_idx,
    input  logic [7:0]                buf_data,
    input  logic                      buf_clear,
    input  logic                      commit,
    input  logic [MEM_AW-PAGE_AW-1:0] page_base,
    input  logic [MEM_AW-1:0]         rd_addr,
    output logic [7:0]                rd_data
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam int PAGE  = 1 << PAGE_AW;

    logic [7:0]      mem  [DEPTH];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] vld;

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    always_ff @(posedge clk) begin
        if (rst || buf_clear || commit) vld <= '0;
        else if (buf_we) vld[buf_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE; i++) begin
                if (vld[i]) mem[{page_base, PAGE_AW'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_paged_mem_slave.sv
module i2c_paged_mem_slave
    import i2cpm_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         MEM_AW      = 8,
    parameter int         PAGE_AW     = 5,
    parameter int         BUSY_CYCLES = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam int HW = MEM_AW - PAGE_AW;

    bus_evt_t            ev;
    logic                scl_q;
    slv_state_e          st;
    logic [2:0]          bitcnt;
    logic [7:0]          shreg;
    logic                got;
    logic [1:0]          idx;
    logic [7:0]          hi_q;
    logic [MEM_AW-1:0]   ptr;
    logic                has_data;
    logic [BW-1:0]       busy_cnt;
    logic                oe;
    logic                we_q, clr_q, commit_q;
    logic [PAGE_AW-1:0]  widx_q;
    logic [7:0]          wdata_q;
    logic [7:0]          rd_data;
    logic [15:0]         full_a;

    assign full_a = {hi_q, shreg};
    assign sda_oe = oe;

    i2cpm_line_sync i_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev), .scl_q(scl_q)
    );

    i2cpm_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) i_store (
        .clk(clk), .rst(rst),
        .buf_we(we_q), .buf_idx(widx_q), .buf_data(wdata_q),
        .buf_clear(clr_q), .commit(commit_q),
        .page_base(ptr[MEM_AW-1:PAGE_AW]),
        .rd_addr(ptr), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            got      <= 1'b0;
            idx      <= '0;
            hi_q     <= '0;
            ptr      <= '0;
            has_data <= 1'b0;
            busy_cnt <= '0;
            oe       <= 1'b0;
            we_q     <= 1'b0;
            clr_q    <= 1'b0;
            commit_q <= 1'b0;
            widx_q   <= '0;
            wdata_q  <= '0;
        end else begin
            we_q     <= 1'b0;
            clr_q    <= 1'b0;
            commit_q <= 1'b0;
            if (busy_cnt != '0) busy_cnt <= busy_cnt - BW'(1);

            if (ev.start) begin
                st       <= S_ADDR;
                bitcnt   <= '0;
                got      <= 1'b0;
                oe       <= 1'b0;
                idx      <= '0;
                clr_q    <= 1'b1;
                has_data <= 1'b0;
            end else if (ev.stop) begin
                st  <= S_IDLE;
                oe  <= 1'b0;
                got <= 1'b0;
                if (has_data) begin
                    commit_q <= 1'b1;
                    busy_cnt <= BW'(BUSY_CYCLES);
                end
                has_data <= 1'b0;
            end else begin
                case (st)
                    S_ADDR, S_WRX: begin
                        if (ev.rise) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) got <= 1'b1;
                        end else if (ev.fall && got) begin
                            got <= 1'b0;
                            if (st == S_ADDR) begin
                                if (addr_hit(shreg, DEV_ADDR) && busy_cnt == '0) begin
                                    st <= S_AACK;
                                    oe <= 1'b1;
                                end else begin
                                    st <= S_WAIT;
                                end
                            end else begin
                                st <= S_WACK;
                                oe <= 1'b1;
                                if (idx == 2'd0) begin
                                    hi_q <= shreg;
                                end else if (idx == 2'd1) begin
                                    ptr <= full_a[MEM_AW-1:0];
                                end else begin
                                    we_q     <= 1'b1;
                                    widx_q   <= ptr[PAGE_AW-1:0];
                                    wdata_q  <= shreg;
                                    has_data <= 1'b1;
                                    ptr      <= {ptr[MEM_AW-1:PAGE_AW], ptr[PAGE_AW-1:0] + PAGE_AW'(1)};
                                end
                                if (idx != 2'd2) idx <= idx + 2'd1;
                            end
                        end
                    end
                    S_AACK: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (shreg[0]) begin
                                st    <= S_TX;
                                oe    <= ~rd_data[7];
                                shreg <= {rd_data[6:0], 1'b0};
                            end else begin
                                st <= S_WRX;
                                oe <= 1'b0;
                            end
                        end
                    end
                    S_WACK: begin
                        if (ev.fall) begin
                            st     <= S_WRX;
                            oe     <= 1'b0;
                            bitcnt <= '0;
                        end
                    end
                    S_TX: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) got <= 1'b1;
                        end else if (ev.fall) begin
                            if (got) begin
                                got <= 1'b0;
                                oe  <= 1'b0;
                                st  <= S_RACK;
                                ptr <= ptr + MEM_AW'(1);
                            end else begin
                                oe    <= ~shreg[7];
                                shreg <= {shreg[6:0], 1'b0};
                            end
                        end
                    end
                    S_RACK: begin
                        if (ev.rise) begin
                            got <= ~ev.sda;
                        end else if (ev.fall) begin
                            got <= 1'b0;
                            if (got) begin
                                st     <= S_TX;
                                bitcnt <= '0;
                                oe     <= ~rd_data[7];
                                shreg  <= {rd_data[6:0], 1'b0};
                            end else begin
                                st <= S_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: an address ACK is only ever given with a matching device byte held
    a_r1_ack_needs_match: assert property (@(posedge clk) disable iff (rst)
        (st == S_AACK) |-> (shreg[7:1] == DEV_ADDR));

    // R7: no address ACK while the busy window is open
    a_r7_busy_blocks_ack: assert property (@(posedge clk) disable iff (rst)
        (busy_cnt != '0) |-> (st != S_AACK));

    // R8: data drive is stable while the sampled clock stays high
    a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        (scl_q && $past(scl_q)) |-> $stable(oe));

    // R3: page bits of the pointer hold while buffered data is pending
    a_r3_page_fixed: assert property (@(posedge clk) disable iff (rst)
        (has_data && $past(has_data)) |-> (ptr[MEM_AW-1:PAGE_AW] == $past(ptr[MEM_AW-1:PAGE_AW])));

    // R9: every START lands in address reception with a clear bit count
    a_r9_start_resets: assert property (@(posedge clk) disable iff (rst)
        $past(ev.start) |-> (st == S_ADDR && bitcnt == 3'd0));

    // R6: after an abandoned read the line is released
    a_r6_wait_released: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT) |-> !oe);

    initial assert (HW >= 1 && MEM_AW <= 16);

endmodule

// File: tb/test_i2c_paged_mem_slave.sv
`timescale 1ns/1ps
module test_i2c_paged_mem_slave;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         BUSY = 1500;
    localparam int         Q    = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    i2c_paged_mem_slave #(.DEV_ADDR(DEV), .MEM_AW(8), .PAGE_AW(5), .BUSY_CYCLES(BUSY))
    i_i2c_paged_mem_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #(Q);
        scl_m = 1'b1; #(Q);
        sda_m = 1'b0; #(Q);
        scl_m = 1'b0; #(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #(Q);
        scl_m = 1'b1; #(Q);
        sda_m = 1'b1; #(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    #(Q);
        scl_m = 1'b1; #(Q);
        #(Q);
        scl_m = 1'b0; #(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        sda_m = 1'b1; #(Q);
        scl_m = 1'b1; #(Q);
        ack = ~sda_line; #(Q);
        scl_m = 1'b0; #(Q);
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #(Q); scl_m = 1'b1; #(Q);
            d[i] = sda_line; #(Q);
            scl_m = 1'b0; #(Q);
        end
        sda_m = nack; #(Q);
        scl_m = 1'b1; #(Q);
        #(Q);
        scl_m = 1'b0; #(Q);
    endtask

    task automatic wait_busy();
        repeat (BUSY + 200) @(posedge clk);
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [7:0] d [4], input int n, input string req);
        logic ack;
        bus_start();
        wbyte({DEV, 1'b0}, ack); chk({req, " dev ack"}, ack, 1);
        wbyte(a[15:8], ack);     chk({req, " hi ack"}, ack, 1);
        wbyte(a[7:0], ack);      chk({req, " lo ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            wbyte(d[i], ack); chk({req, " data ack"}, ack, 1);
        end
        bus_stop();
    endtask

    task automatic mem_read(input logic [15:0] a, input int n, output logic [7:0] q [4]);
        logic ack;
        bus_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(a[15:8], ack);
        wbyte(a[7:0], ack);
        bus_start();
        wbyte({DEV, 1'b1}, ack); chk("R4 read dev ack", ack, 1);
        for (int i = 0; i < n; i++) rbyte(i == n - 1, q[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R10 released after reset", sda_oe, 0);
    endtask

    task automatic t_wrong_addr();
        logic ack;
        bus_start();
        wbyte({7'h23, 1'b0}, ack);
        chk("R1 foreign address NACK", ack, 0);
        bus_stop();
    endtask

    task automatic t_write_read();
        logic [7:0] d [4] = '{8'hA0, 8'hA1, 8'hA2, 8'h00};
        logic [7:0] q [4];
        mem_write(16'h0110, d, 3, "R2");
        wait_busy();
        mem_read(16'h0010, 3, q);
        for (int i = 0; i < 3; i++) chk("R2 R4 random read data", q[i], d[i]);
    endtask

    task automatic t_busy();
        logic [7:0] d [4] = '{8'h5A, 8'h00, 8'h00, 8'h00};
        logic [7:0] q [4];
        logic ack;
        mem_write(16'h0040, d, 1, "R7");
        bus_start();
        wbyte({DEV, 1'b0}, ack); chk("R7 NACK inside busy window", ack, 0);
        bus_stop();
        wait_busy();
        bus_start();
        wbyte({DEV, 1'b0}, ack); chk("R7 ACK after busy window", ack, 1);
        bus_stop();
        mem_read(16'h0040, 1, q);
        chk("R7 committed byte", q[0], 8'h5A);
    endtask

    task automatic t_page_wrap();
        logic [7:0] d [4] = '{8'hB0, 8'hB1, 8'hB2, 8'h00};
        logic [7:0] q [4];
        mem_write(16'h003E, d, 3, "R3");
        wait_busy();
        mem_read(16'h003E, 2, q);
        chk("R3 page byte 3E", q[0], 8'hB0);
        chk("R3 page byte 3F", q[1], 8'hB1);
        mem_read(16'h0020, 1, q);
        chk("R3 wrapped into page start 20", q[0], 8'hB2);
    endtask

    task automatic t_seq_wrap();
        logic [7:0] d0 [4] = '{8'hD0, 8'h00, 8'h00, 8'h00};
        logic [7:0] d1 [4] = '{8'hC0, 8'hC1, 8'h00, 8'h00};
        logic [7:0] q [4];
        mem_write(16'h0000, d0, 1, "R5");
        wait_busy();
        mem_write(16'h00FE, d1, 2, "R5");
        wait_busy();
        mem_read(16'h00FE, 3, q);
        chk("R5 seq FE", q[0], 8'hC0);
        chk("R5 seq FF", q[1], 8'hC1);
        chk("R5 wrap to 00", q[2], 8'hD0);
    endtask

    task automatic t_discard_rstart();
        logic [7:0] d [4] = '{8'h11, 8'h00, 8'h00, 8'h00};
        logic [7:0] q [4];
        logic ack;
        mem_write(16'h0050, d, 1, "R9");
        wait_busy();
        bus_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'h00, ack);
        wbyte(8'h50, ack);
        wbyte(8'h99, ack);
        bus_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'h00, ack);
        wbyte(8'h50, ack);
        bus_stop();
        bus_start();
        wbyte({DEV, 1'b0}, ack); chk("R7 no busy after address-only write", ack, 1);
        bus_stop();
        mem_read(16'h0050, 1, q);
        chk("R9 repeated START discards buffer", q[0], 8'h11);
    endtask

    task automatic t_nack_release();
        logic [7:0] b;
        logic ack;
        bus_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'h00, ack);
        wbyte(8'h10, ack);
        bus_start();
        wbyte({DEV, 1'b1}, ack);
        rbyte(1'b1, b);
        chk("R6 byte before NACK", b, 8'hA0);
        rbyte(1'b1, b);
        chk("R6 line released after NACK", b, 8'hFF);
        bus_stop();
    endtask

    task automatic t_abort_midbyte();
        logic [7:0] d [4] = '{8'h12, 8'h00, 8'h00, 8'h00};
        logic [7:0] q [4];
        logic ack;
        mem_write(16'h0030, d, 1, "R9");
        wait_busy();
        bus_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'h00, ack);
        wbyte(8'h30, ack);
        wbyte(8'h77, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        wbyte({DEV, 1'b0}, ack); chk("R9 address accepted after mid-byte START", ack, 1);
        bus_stop();
        mem_read(16'h0030, 1, q);
        chk("R9 aborted data not committed", q[0], 8'h12);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst = 1'b0;
        repeat (5) @(posedge clk);
        #3;
        t_reset();
        t_wrong_addr();
        t_write_read();
        t_busy();
        t_page_wrap();
        t_seq_wrap();
        t_discard_rstart();
        t_nack_release();
        t_abort_midbyte();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(3_000_000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule